// File: doc/BRIEF.md
# I2C Multi-Master Bus-Free Guard

This block sits beside an I2C controller on a bus shared by several masters. It watches SDA and SCL on every clock cycle, whatever state the local controller or its software is in. The raw lines pass through a synchronizer and a glitch filter. The block then recognises START, repeated START and STOP conditions and keeps a bus-busy indication. Each START and each STOP raises its own single-cycle pulse output, apart from any byte-level event.

A local master must not begin a transfer while another master owns the bus. A local master must also not begin one while the bus has only just gone idle. When the local slave logic reports that a received message ended (STOP or repeated START), the guard loads a quiet-countdown from a configurable reload value. The recommended reload value is 4. On each sample tick the countdown goes down by one if both lines are high. If either line is low, it goes back to its full value. Separately, a bus-free timer counts system cycles since the last STOP.

A start request from the local master is granted with a one-cycle pulse only when all of these hold:
- the countdown is at zero,
- the bus is not busy,
- the bus-free time has elapsed.

Until then the request is reported as held.

Top module: `i2c_idle_gate`

## Requirements
- R1: A STOP (filtered SDA rising while filtered SCL stays high) produces a one-cycle `bus_stop` pulse and clears the busy state. This happens whether or not a local transfer or slave event is in progress.
- R2: A START or repeated START (filtered SDA falling while filtered SCL stays high) produces a one-cycle `bus_start` pulse and sets the busy state. This happens even when no local transfer is active.
- R3: `bus_busy` is 1 while the busy state is set or while either filtered line is low. After reset it is 0 with both lines high.
- R4: A level on SDA or SCL that lasts fewer than FILT_LEN synchronized samples does not change the filtered line, so it creates no START or STOP.
- R5: A one-cycle `slv_stop_evt` loads the quiet-countdown with `cfg_reload`. While the countdown is non-zero, a start request is held and not granted.
- R6: A sample tick comes every `cfg_tick_div`+1 cycles. On a tick with a non-zero countdown, the countdown reloads to `cfg_reload` if either filtered line is low, and drops by one if both are high. `slv_stop_evt` takes priority over a tick in the same cycle.
- R7: With `cfg_reload` = 0 the countdown stays at zero, so starts are gated only by the busy state and the bus-free timer.
- R8: The bus-free timer restarts at each STOP and stops and clears at each START. A grant needs at least `cfg_free_min` cycles counted since the last STOP.
- R9: `start_grant` is a one-cycle pulse. It is given the cycle after `start_req` is high with no earlier grant for this request and all conditions met. After a grant there is no new grant until `start_req` has been low. A request dropped before its grant gets none.
- R10: `start_hold` is 1 while a request is pending and a condition blocks it. It is never 1 in the same cycle as `start_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_raw | input | 1 | Asynchronous SDA line sample |
| scl_raw | input | 1 | Asynchronous SCL line sample |
| slv_stop_evt | input | 1 | One-cycle pulse: local slave saw the end of a received message |
| start_req | input | 1 | Local master asks to begin a transfer; held until granted or withdrawn |
| cfg_reload | input | CNT_W | Quiet-countdown reload value; 0 disables the countdown |
| cfg_tick_div | input | TICK_W | Sample tick period minus one, in clock cycles |
| cfg_free_min | input | FREE_W | Minimum cycles from STOP to a grant |
| bus_busy | output | 1 | Bus is in use or a line is low |
| bus_start | output | 1 | One-cycle pulse on START or repeated START |
| bus_stop | output | 1 | One-cycle pulse on STOP |
| start_grant | output | 1 | One-cycle grant of the pending start request |
| start_hold | output | 1 | Pending request is being held |

## Verification
A change on a raw line reaches the filtered line SYNC_STAGES+FILT_LEN cycles after the clock edge that first samples it, so `bus_busy` follows 5 cycles later with the default parameters. The `bus_start` and `bus_stop` pulses follow one cycle after that. `start_grant` rises one cycle after the cycle in which the request and all conditions are present, and `start_hold` follows them in the same cycle.

The bench drives inputs just after a rising edge. It advances a behavioural reference model at each rising edge, with the same sample-history arithmetic for these delays, and compares every output at the falling edge. Directed scenarios add pulse and grant counts. Each count is read only after a wait that is longer than the worst-case tick alignment of the countdown and than the bus-free threshold, or clearly shorter than the earliest possible grant.

// File: rtl/i2c_idle_gate_pkg.sv
package i2c_idle_gate_pkg;

   typedef struct packed {
      logic scl;
      logic sda;
   } i2c_lines_t;

   localparam i2c_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
   import i2c_idle_gate_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_raw,
   input  logic       scl_raw,
   output i2c_lines_t filt,
   output i2c_lines_t filt_prev
);

   localparam int NLINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_line_cond: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("i2c_line_cond: FILT_LEN must be at least 2");
   end

   logic [NLINES-1:0] raw_v;
   logic [NLINES-1:0] filt_v;
   logic [NLINES-1:0] prev_v;

   assign raw_v = {scl_raw, sda_raw};

   for (genvar li = 0; li < NLINES; li++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;
      logic [FILT_LEN-1:0]    hist_q;
      logic                   lvl_q;
      logic                   lvl_prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q     <= '1;
            hist_q     <= '1;
            lvl_q      <= 1'b1;
            lvl_prev_q <= 1'b1;
         end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], raw_v[li]};
            hist_q     <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
               lvl_q <= 1'b1;
            else if (~|hist_q)
               lvl_q <= 1'b0;
            lvl_prev_q <= lvl_q;
         end
      end

      assign filt_v[li] = lvl_q;
      assign prev_v[li] = lvl_prev_q;
   end

   assign filt      = '{scl: filt_v[1], sda: filt_v[0]};
   assign filt_prev = '{scl: prev_v[1], sda: prev_v[0]};

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
   import i2c_idle_gate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  i2c_lines_t filt,
   input  i2c_lines_t filt_prev,
   output logic       start_now,
   output logic       stop_now,
   output logic       busy_q,
   output logic       start_pulse,
   output logic       stop_pulse
);

   logic scl_steady_hi;

   assign scl_steady_hi = filt.scl & filt_prev.scl;
   assign start_now     = scl_steady_hi &  filt_prev.sda & ~filt.sda;
   assign stop_now      = scl_steady_hi & ~filt_prev.sda &  filt.sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
      end else begin
         start_pulse <= start_now;
         stop_pulse  <= stop_now;
         if (start_now)
            busy_q <= 1'b1;
         else if (stop_now)
            busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/i2c_quiet_count.sv
module i2c_quiet_count #(
   parameter int CNT_W  = 4,
   parameter int TICK_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              line_low,
   input  logic [CNT_W-1:0]  reload_val,
   input  logic [TICK_W-1:0] tick_div,
   output logic              quiet_done
);

   if (CNT_W < 1 || TICK_W < 1) begin : g_bad_w
      $error("i2c_quiet_count: widths must be positive");
   end

   logic [TICK_W-1:0] tick_cnt_q;
   logic              tick;
   logic [CNT_W-1:0]  remain_q;

   assign tick = (tick_cnt_q == tick_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_cnt_q <= '0;
      else if (tick)
         tick_cnt_q <= '0;
      else
         tick_cnt_q <= tick_cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= '0;
      else if (load)
         remain_q <= reload_val;
      else if (tick && remain_q != '0)
         remain_q <= line_low ? reload_val : remain_q - 1'b1;
   end

   assign quiet_done = (remain_q == '0);

endmodule

// File: rtl/i2c_free_timer.sv
module i2c_free_timer #(
   parameter int FREE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_now,
   input  logic              stop_now,
   input  logic [FREE_W-1:0] free_min,
   output logic              free_ok
);

   if (FREE_W < 1) begin : g_bad_w
      $error("i2c_free_timer: FREE_W must be positive");
   end

   logic [FREE_W-1:0] elapsed_q;
   logic              running_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
         running_q <= 1'b1;
      end else if (start_now) begin
         elapsed_q <= '0;
         running_q <= 1'b0;
      end else if (stop_now) begin
         elapsed_q <= '0;
         running_q <= 1'b1;
      end else if (running_q && elapsed_q < free_min) begin
         elapsed_q <= elapsed_q + 1'b1;
      end
   end

   assign free_ok = running_q && (elapsed_q >= free_min);

endmodule

// File: rtl/i2c_idle_gate.sv
module i2c_idle_gate
   import i2c_idle_gate_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int CNT_W       = 4,
   parameter int TICK_W      = 12,
   parameter int FREE_W      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_raw,
   input  logic              scl_raw,
   input  logic              slv_stop_evt,
   input  logic              start_req,
   input  logic [CNT_W-1:0]  cfg_reload,
   input  logic [TICK_W-1:0] cfg_tick_div,
   input  logic [FREE_W-1:0] cfg_free_min,
   output logic              bus_busy,
   output logic              bus_start,
   output logic              bus_stop,
   output logic              start_grant,
   output logic              start_hold
);

   i2c_lines_t filt, filt_prev;
   logic start_now, stop_now, busy_q;
   logic line_low, quiet_done, free_ok;
   logic may_start, grant_now, served_q;

   i2c_line_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
   ) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_raw  (sda_raw),
      .scl_raw  (scl_raw),
      .filt     (filt),
      .filt_prev(filt_prev)
   );

   i2c_cond_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .filt       (filt),
      .filt_prev  (filt_prev),
      .start_now  (start_now),
      .stop_now   (stop_now),
      .busy_q     (busy_q),
      .start_pulse(bus_start),
      .stop_pulse (bus_stop)
   );

   assign line_low = ~(filt.sda & filt.scl);
   assign bus_busy = busy_q | line_low;

   i2c_quiet_count #(
      .CNT_W (CNT_W),
      .TICK_W(TICK_W)
   ) u_quiet (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (slv_stop_evt),
      .line_low  (line_low),
      .reload_val(cfg_reload),
      .tick_div  (cfg_tick_div),
      .quiet_done(quiet_done)
   );

   i2c_free_timer #(
      .FREE_W(FREE_W)
   ) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_now(start_now),
      .stop_now (stop_now),
      .free_min (cfg_free_min),
      .free_ok  (free_ok)
   );

   assign may_start  = ~bus_busy & quiet_done & free_ok;
   assign grant_now  = start_req & ~served_q & may_start;
   assign start_hold = start_req & ~served_q & ~may_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_grant <= 1'b0;
         served_q    <= 1'b0;
      end else begin
         start_grant <= grant_now;
         served_q    <= grant_now | (served_q & start_req);
      end
   end

endmodule

// File: rtl/i2c_idle_gate_chk.sv
module i2c_idle_gate_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slv_stop_evt,
   input logic             start_req,
   input logic [CNT_W-1:0] cfg_reload,
   input logic             bus_busy,
   input logic             bus_start,
   input logic             bus_stop,
   input logic             start_grant,
   input logic             start_hold
);

   a_r1_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |-> !bus_busy);

   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |-> bus_busy);

   a_r2_cond_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_start && bus_stop));

   a_r5_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(slv_stop_evt) && $past(cfg_reload) != '0) |=> !start_grant);

   a_r9_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_grant |=> !start_grant);

   a_r9_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
      start_grant |-> ($past(start_req) && !$past(bus_busy)));

   a_r10_hold_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_grant && start_hold));

endmodule

bind i2c_idle_gate i2c_idle_gate_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slv_stop_evt(slv_stop_evt),
   .start_req   (start_req),
   .cfg_reload  (cfg_reload),
   .bus_busy    (bus_busy),
   .bus_start   (bus_start),
   .bus_stop    (bus_stop),
   .start_grant (start_grant),
   .start_hold  (start_hold)
);

// File: tb/i2c_idle_gate_bench.sv
`timescale 1ns/1ps
module i2c_idle_gate_bench;

   localparam int S  = 2;
   localparam int F  = 3;
   localparam int CW = 4;
   localparam int TW = 12;
   localparam int FW = 10;
   localparam int H  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sda = 1'b1, scl = 1'b1, evt = 1'b0, req = 1'b0;
   logic [CW-1:0] reload = 4'd4;
   logic [TW-1:0] div = 12'd9;
   logic [FW-1:0] fmin = 10'd20;
   logic bus_busy, bus_start, bus_stop, start_grant, start_hold;

   int n_run = 0, n_fail = 0, cyc = 0;
   int n_start = 0, n_stop = 0, n_grant = 0;

   always #2.5 clk = ~clk;

   i2c_idle_gate #(.SYNC_STAGES(S), .FILT_LEN(F), .CNT_W(CW), .TICK_W(TW), .FREE_W(FW)) u_i2c_idle_gate (
      .clk(clk), .rst_n(rst_n), .sda_raw(sda), .scl_raw(scl),
      .slv_stop_evt(evt), .start_req(req), .cfg_reload(reload),
      .cfg_tick_div(div), .cfg_free_min(fmin),
      .bus_busy(bus_busy), .bus_start(bus_start), .bus_stop(bus_stop),
      .start_grant(start_grant), .start_hold(start_hold));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [15:0] h_sda, h_scl;
   bit m_fs, m_fc, m_ps, m_pc, m_busy, m_st, m_sp, m_grant, m_done, m_run;
   int m_tick, m_q, m_free;

   function automatic bit m_ok();
      return !(m_busy || !(m_fs && m_fc)) && m_q == 0 && m_run && m_free >= int'(fmin);
   endfunction

   function automatic bit settle(input bit [15:0] h, input bit cur);
      bit all1 = 1'b1, all0 = 1'b1;
      for (int k = S + 1; k <= S + F; k++) begin
         if (h[k]) all0 = 1'b0; else all1 = 1'b0;
      end
      return all1 ? 1'b1 : (all0 ? 1'b0 : cur);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_sda = '1; h_scl = '1;
         m_fs = 1; m_fc = 1; m_ps = 1; m_pc = 1;
         m_busy = 0; m_st = 0; m_sp = 0; m_grant = 0; m_done = 0;
         m_run = 1; m_tick = 0; m_q = 0; m_free = 0;
      end else begin
         bit st, sp, low, tk, gc, nfs, nfc;
         st  = m_ps && !m_fs && m_fc && m_pc;
         sp  = !m_ps && m_fs && m_fc && m_pc;
         low = !(m_fs && m_fc);
         tk  = (m_tick == int'(div));
         gc  = req && !m_done && m_ok();
         m_grant = gc;
         m_done  = gc || (m_done && req);
         m_st = st; m_sp = sp;
         if (st) m_busy = 1; else if (sp) m_busy = 0;
         m_tick = tk ? 0 : m_tick + 1;
         if (evt) m_q = int'(reload);
         else if (tk && m_q != 0) m_q = low ? int'(reload) : m_q - 1;
         if (st) begin m_run = 0; m_free = 0; end
         else if (sp) begin m_run = 1; m_free = 0; end
         else if (m_run && m_free < int'(fmin)) m_free++;
         h_sda = {h_sda[14:0], sda};
         h_scl = {h_scl[14:0], scl};
         nfs = settle(h_sda, m_fs);
         nfc = settle(h_scl, m_fc);
         m_ps = m_fs; m_pc = m_fc; m_fs = nfs; m_fc = nfc;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit eb, eh;
         eb = m_busy || !(m_fs && m_fc);
         eh = req && !m_done && !m_ok();
         chk(bus_busy == eb, "R3 bus_busy", bus_busy, eb);
         chk(bus_start == m_st, "R2 bus_start", bus_start, m_st);
         chk(bus_stop == m_sp, "R1 bus_stop", bus_stop, m_sp);
         chk(start_grant == m_grant, "R9 start_grant", start_grant, m_grant);
         chk(start_hold == eh, "R10 start_hold", start_hold, eh);
         if (bus_start) n_start++;
         if (bus_stop) n_stop++;
         if (start_grant) n_grant++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic wcyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic line(input logic d, input logic c, input int n);
      sda = d; scl = c;
      wcyc(n);
   endtask

   task automatic clr();
      n_start = 0; n_stop = 0; n_grant = 0;
   endtask

   task automatic pulse_evt();
      evt = 1'b1; wcyc(1); evt = 1'b0;
   endtask

   task automatic b_start();   line(1, 1, H); line(0, 1, H); line(0, 0, H); endtask
   task automatic b_bit(input logic b); line(b, 0, H); line(b, 1, H); line(b, 0, H); endtask
   task automatic b_rstart();  line(1, 0, H); line(1, 1, H); line(0, 1, H); line(0, 0, H); endtask
   task automatic b_stop();    line(0, 0, H); line(0, 1, H); line(1, 1, H); endtask

   initial begin
      wcyc(4);
      rst_n = 1'b1;
      wcyc(2);
      chk(bus_busy == 0, "R3 reset busy", bus_busy, 0);
      chk(start_grant == 0, "R9 reset grant", start_grant, 0);

      // R9: held request gets exactly one grant
      wcyc(30); clr();
      req = 1; wcyc(20);
      chk(n_grant == 1, "R9 single grant", n_grant, 1);
      req = 0; wcyc(2);

      // R1 R2 R3: transaction with request held while busy
      clr();
      b_start(); req = 1; b_bit(1); b_bit(0);
      chk(start_hold == 1, "R3 hold while busy", start_hold, 1);
      b_bit(1); b_stop(); wcyc(40);
      chk(n_start == 1, "R2 start count", n_start, 1);
      chk(n_stop == 1, "R1 stop count", n_stop, 1);
      chk(n_grant == 1, "R8 grant after free", n_grant, 1);
      req = 0; wcyc(2);

      // R8: bus-free time after STOP
      clr();
      b_start(); b_bit(0); line(0, 0, H); line(0, 1, H);
      sda = 1; req = 1; wcyc(20);
      chk(n_grant == 0, "R8 free time not elapsed", n_grant, 0);
      wcyc(30);
      chk(n_grant == 1, "R8 free time elapsed", n_grant, 1);
      req = 0; wcyc(2);

      // R5: countdown after slave stop event
      clr();
      pulse_evt(); req = 1; wcyc(25);
      chk(n_grant == 0, "R5 countdown holds", n_grant, 0);
      wcyc(60);
      chk(n_grant == 1, "R5 countdown done", n_grant, 1);
      req = 0; wcyc(2);

      // R6: low line reloads the countdown
      clr();
      pulse_evt(); req = 1;
      scl = 0; wcyc(60);
      chk(n_grant == 0, "R6 held while low", n_grant, 0);
      chk(bus_busy == 1, "R3 busy while scl low", bus_busy, 1);
      scl = 1; wcyc(25);
      chk(n_grant == 0, "R6 reloaded", n_grant, 0);
      wcyc(60);
      chk(n_grant == 1, "R6 grant after quiet", n_grant, 1);
      req = 0; wcyc(2);

      // R7: reload of zero disables countdown
      reload = 0; clr();
      pulse_evt(); req = 1; wcyc(5);
      chk(n_grant == 1, "R7 no countdown", n_grant, 1);
      req = 0; reload = 4; wcyc(2);

      // R4: short glitches ignored
      clr();
      line(1, 1, 10); line(0, 1, 2); line(1, 1, 10);
      line(1, 0, 2); line(1, 1, 10);
      chk(n_start == 0, "R4 no start from glitch", n_start, 0);
      chk(n_stop == 0, "R4 no stop from glitch", n_stop, 0);

      // R1 R2: monitoring continues right after slave event; repeated START
      clr();
      pulse_evt(); b_start();
      chk(n_start == 1, "R2 start after event", n_start, 1);
      chk(bus_busy == 1, "R2 busy after event", bus_busy, 1);
      b_bit(1); b_rstart(); b_bit(0); b_stop(); wcyc(10);
      chk(n_start == 2, "R2 repeated start", n_start, 2);
      chk(n_stop == 1, "R1 stop after event", n_stop, 1);
      wcyc(60);

      // R9: withdrawn request is never granted
      clr();
      b_start(); req = 1; b_bit(1); req = 0; b_stop(); wcyc(60);
      chk(n_grant == 0, "R9 withdrawn", n_grant, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule